// File: doc/BRIEF.md
# Variable-Page-Size Fully-Associative Translation Buffer

This block is a unified address translation buffer shared by instruction and data traffic. It holds a parameterised number of entries (64 by default), and it is fully associative. Each entry has two 32-bit words. The tag word holds an effective page number, a page-size code and a valid flag. The data word holds a real page number, execute and write permissions, a 4-bit zone selector and four storage attribute flags. The page-size code belongs to each entry, so one array can mix pages from 1 KB to 16 MB. The code sets how many low address bits the entry ignores when it compares and passes through unchanged when it translates.

A combinational lookup port takes an effective address. In the same cycle it returns a hit flag, the index of the matching entry, the translated real address, the permissions, the zone and the attributes. It also returns a flag that is raised when more than one entry matches. The hardware never fills the array. Software maintains it through one command port that offers three operations: read a word of an entry by index, write a word of an entry by index, and search by effective address. Reads and searches return their results one clock later.

Top module: `vpt_tlb`

## Requirements
- R1: A synchronous active-high reset clears both words of every entry to zero. After reset, every lookup misses and every read returns zero.
- R2: The command port `sw_op` uses the encoding 0 = idle, 1 = read, 2 = write, 3 = search. A write stores `sw_wdata` into entry `sw_idx`. With `sw_word` = 0 it writes the tag word and with `sw_word` = 1 it writes the data word. The other word of that entry and all other entries keep their contents.
- R3: A read returns the selected word on `sw_rdata` in the cycle after the read is issued, and `sw_rdata` holds that value until the next read. Tag word layout: bits 31..10 page number, bits 9..7 size code, bit 6 valid; bits 5..0 always read as zero. Data word layout: bits 31..10 real page number, bit 9 execute, bit 8 write, bits 7..4 zone, bits 3..0 attributes (bit 3 write-through, bit 2 cache-inhibit, bit 1 coherent, bit 0 guarded). Every bit of the data word reads back as written.
- R4: An entry with size code k (0..7, meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M or 16M bytes) matches when it is valid and the effective address agrees with its page number on bits 31 down to 10+2k. Bits below 10+2k are ignored.
- R5: On a hit, `lk_pa` takes the entry's real page number on bits 31 down to 10+2k and takes the effective address on bits below 10+2k.
- R6: On a hit, `lk_idx`, `lk_ex`, `lk_wr`, `lk_zone` and `lk_attr` come from the matching entry. On a miss, every lookup output is zero.
- R7: When several valid entries match, the lowest index supplies the result and `lk_multi` is 1. When one entry or no entry matches, `lk_multi` is 0.
- R8: A search returns `sw_found` and `sw_fidx`, using the same match and lowest-index rule as a lookup, in the cycle after it is issued. Both outputs hold until the next search.
- R9: A write changes lookups from the next cycle on. A lookup or search in the same cycle as a write sees the old contents.
- R10: An entry whose tag word has the valid bit clear never produces a hit, whatever its page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_idx | output | IDX_W (6) | Index of the winning entry |
| lk_pa | output | 32 | Translated real address |
| lk_ex | output | 1 | Execute permission |
| lk_wr | output | 1 | Write permission |
| lk_zone | output | 4 | Zone selector |
| lk_attr | output | 4 | Attribute flags W, I, M, G |
| sw_op | input | 2 | Command: 0 idle, 1 read, 2 write, 3 search |
| sw_idx | input | IDX_W (6) | Entry index for read and write |
| sw_word | input | 1 | Word select: 0 tag, 1 data |
| sw_wdata | input | 32 | Write data |
| sw_ea | input | 32 | Search effective address |
| sw_rdata | output | 32 | Read result, registered |
| sw_found | output | 1 | Search hit, registered |
| sw_fidx | output | IDX_W (6) | Search index, registered |

## Verification
The bench builds the block with its default of 64 entries, so it can address the top index and fill the entries near both ends of the priority order. Directed steps write entries with size codes 0, 3 and 7, then look up addresses just inside and just outside each page boundary. They also place overlapping pages at a high and a low index to exercise the lowest-index rule and the multi-hit flag. A random phase draws page numbers from a few clustered bases, so overlaps, invalidations and same-cycle write/lookup collisions happen often. A behavioural model checks every cycle.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
    localparam int WORD_W  = 32;
    localparam int OFF_MIN = 10;
    localparam int PN_W    = WORD_W - OFF_MIN;
    localparam int PSZ_W   = 3;
    localparam int TAG_PAD = OFF_MIN - PSZ_W - 1;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_READ   = 2'd1,
        SW_WRITE  = 2'd2,
        SW_SEARCH = 2'd3
    } sw_op_e;

    typedef struct packed {
        logic [PN_W-1:0]  epn;
        logic [PSZ_W-1:0] psz;
        logic             valid;
    } tag_t;

    typedef struct packed {
        logic [PN_W-1:0] rpn;
        logic            ex;
        logic            wr;
        logic [3:0]      zone;
        logic [3:0]      attr;
    } dat_t;

    // Ones on the bits that lie above the page offset for a given size code.
    function automatic logic [WORD_W-1:0] keep_mask(input logic [PSZ_W-1:0] psz);
        logic [WORD_W-1:0] m;
        m = '1;
        return m << (OFF_MIN + 2 * int'(psz));
    endfunction

    function automatic tag_t tag_unpack(input logic [WORD_W-1:0] w);
        tag_t t;
        t.epn   = w[WORD_W-1:OFF_MIN];
        t.psz   = w[OFF_MIN-1:OFF_MIN-PSZ_W];
        t.valid = w[TAG_PAD];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] tag_pack(input tag_t t);
        return {t.epn, t.psz, t.valid, {TAG_PAD{1'b0}}};
    endfunction
endpackage

// File: rtl/vpt_store.sv
module vpt_store
    import vpt_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic                      wsel,
    input  logic [WORD_W-1:0]         wdata,
    output tag_t [ENTRIES-1:0]        tags,
    output dat_t [ENTRIES-1:0]        dats
);
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
            tag_t t_q;
            dat_t d_q;
            logic sel;
            assign sel = we && (widx == IDX_W'(e));
            always_ff @(posedge clk) begin
                if (rst) begin
                    t_q <= '0;
                    d_q <= '0;
                end else if (sel) begin
                    if (wsel) d_q <= dat_t'(wdata);
                    else      t_q <= tag_unpack(wdata);
                end
            end
            assign tags[e] = t_q;
            assign dats[e] = d_q;
        end
    endgenerate
endmodule

// File: rtl/vpt_match.sv
module vpt_match
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic [WORD_W-1:0]   ea,
    input  tag_t [ENTRIES-1:0]  tags,
    output logic [ENTRIES-1:0]  hits
);
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            logic [WORD_W-1:0] km;
            logic [WORD_W-1:0] base;
            assign km      = keep_mask(tags[e].psz);
            assign base    = {tags[e].epn, {OFF_MIN{1'b0}}};
            assign hits[e] = tags[e].valid && (((ea ^ base) & km) == '0);
        end
    endgenerate
endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
    assign any   = |hits;
    assign multi = |(hits & (hits - ENTRIES'(1)));
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       lk_ea,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [31:0]       lk_pa,
    output logic              lk_ex,
    output logic              lk_wr,
    output logic [3:0]        lk_zone,
    output logic [3:0]        lk_attr,
    input  logic [1:0]        sw_op,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_word,
    input  logic [31:0]       sw_wdata,
    input  logic [31:0]       sw_ea,
    output logic [31:0]       sw_rdata,
    output logic              sw_found,
    output logic [IDX_W-1:0]  sw_fidx
);
    sw_op_e              op;
    tag_t [ENTRIES-1:0]  tags;
    dat_t [ENTRIES-1:0]  dats;
    logic [ENTRIES-1:0]  lk_hits, sr_hits;
    logic                lk_any, lk_many, sr_any, sr_many;
    logic [IDX_W-1:0]    lk_sel, sr_sel;
    dat_t                lk_d;
    logic [WORD_W-1:0]   lk_km;

    assign op = sw_op_e'(sw_op);

    vpt_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .we(op == SW_WRITE), .widx(sw_idx),
        .wsel(sw_word), .wdata(sw_wdata), .tags(tags), .dats(dats)
    );

    vpt_match #(.ENTRIES(ENTRIES)) u_lk_match (.ea(lk_ea), .tags(tags), .hits(lk_hits));
    vpt_match #(.ENTRIES(ENTRIES)) u_sr_match (.ea(sw_ea), .tags(tags), .hits(sr_hits));

    vpt_prio #(.ENTRIES(ENTRIES)) u_lk_prio (.hits(lk_hits), .any(lk_any), .multi(lk_many), .idx(lk_sel));
    vpt_prio #(.ENTRIES(ENTRIES)) u_sr_prio (.hits(sr_hits), .any(sr_any), .multi(sr_many), .idx(sr_sel));

    // Lookup result, gated to zero on a miss.
    assign lk_d  = dats[lk_sel];
    assign lk_km = keep_mask(tags[lk_sel].psz);

    always_comb begin
        lk_hit   = lk_any;
        lk_multi = lk_many;
        lk_idx   = lk_any ? lk_sel : '0;
        lk_pa    = '0;
        lk_ex    = 1'b0;
        lk_wr    = 1'b0;
        lk_zone  = '0;
        lk_attr  = '0;
        if (lk_any) begin
            lk_pa   = ({lk_d.rpn, {OFF_MIN{1'b0}}} & lk_km) | (lk_ea & ~lk_km);
            lk_ex   = lk_d.ex;
            lk_wr   = lk_d.wr;
            lk_zone = lk_d.zone;
            lk_attr = lk_d.attr;
        end
    end

    // Command results, registered and held until the next command of the same kind.
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_rdata <= '0;
            sw_found <= 1'b0;
            sw_fidx  <= '0;
        end else begin
            if (op == SW_READ)
                sw_rdata <= sw_word ? WORD_W'(dats[sw_idx]) : tag_pack(tags[sw_idx]);
            if (op == SW_SEARCH) begin
                sw_found <= sr_any;
                sw_fidx  <= sr_any ? sr_sel : '0;
            end
        end
    end

    logic unused_sr_many;
    assign unused_sr_many = sr_many;
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       lk_ea,
    input logic              lk_hit,
    input logic              lk_multi,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [31:0]       lk_pa,
    input logic              lk_ex,
    input logic              lk_wr,
    input logic [3:0]        lk_zone,
    input logic [3:0]        lk_attr,
    input logic [1:0]        sw_op,
    input logic [31:0]       sw_ea,
    input logic [31:0]       sw_rdata,
    input logic              sw_found,
    input logic [IDX_W-1:0]  sw_fidx
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!lk_hit && !lk_multi));

    a_r5_offset_passes: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[9:0] == lk_ea[9:0]));

    a_r6_miss_is_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == '0 && lk_idx == '0 && !lk_ex && !lk_wr && lk_zone == '0 && lk_attr == '0));

    a_r7_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);

    a_r8_search_agrees: assert property (@(posedge clk) disable iff (rst)
        (sw_op == 2'd3 && sw_ea == lk_ea) |=> (sw_found == $past(lk_hit) && sw_fidx == $past(lk_idx)));

    a_r8_search_holds: assert property (@(posedge clk) disable iff (rst)
        (sw_op != 2'd3) |=> ($stable(sw_found) && $stable(sw_fidx)));

    a_r3_read_holds: assert property (@(posedge clk) disable iff (rst)
        (sw_op != 2'd1) |=> $stable(sw_rdata));
endmodule

bind vpt_tlb vpt_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_multi(lk_multi),
    .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_ex(lk_ex), .lk_wr(lk_wr), .lk_zone(lk_zone),
    .lk_attr(lk_attr), .sw_op(sw_op), .sw_ea(sw_ea), .sw_rdata(sw_rdata),
    .sw_found(sw_found), .sw_fidx(sw_fidx)
);

// File: tb/tb_vpt_tlb.sv
module tb_vpt_tlb;
    localparam int N  = 64;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   lk_ea;
    logic          lk_hit, lk_multi, lk_ex, lk_wr;
    logic [IW-1:0] lk_idx;
    logic [31:0]   lk_pa;
    logic [3:0]    lk_zone, lk_attr;
    logic [1:0]    sw_op;
    logic [IW-1:0] sw_idx;
    logic          sw_word;
    logic [31:0]   sw_wdata, sw_ea, sw_rdata;
    logic          sw_found;
    logic [IW-1:0] sw_fidx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural model
    logic [31:0] m_tag [N];
    logic [31:0] m_dat [N];
    logic [31:0] e_rdata;
    logic        e_found;
    int          e_fidx;

    always #4 clk = ~clk;

    vpt_tlb #(.ENTRIES(N)) dut (
        .clk(clk), .rst(rst), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_multi(lk_multi),
        .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_ex(lk_ex), .lk_wr(lk_wr), .lk_zone(lk_zone),
        .lk_attr(lk_attr), .sw_op(sw_op), .sw_idx(sw_idx), .sw_word(sw_word),
        .sw_wdata(sw_wdata), .sw_ea(sw_ea), .sw_rdata(sw_rdata), .sw_found(sw_found),
        .sw_fidx(sw_fidx)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R4: match on bits at and above 10+2k; R10: the valid bit gates it
    function automatic bit m_match(input logic [31:0] t, input logic [31:0] ea);
        int sh;
        sh = 10 + 2 * int'(t[9:7]);
        return t[6] && ((ea >> sh) == (t >> sh));
    endfunction

    function automatic int m_first(input logic [31:0] ea, output int cnt);
        int f;
        f = -1;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (m_match(m_tag[i], ea)) begin
                cnt++;
                if (f < 0) f = i;
            end
        end
        return f;
    endfunction

    task automatic check_lookup();
        int f, cnt, sh;
        logic [31:0] lo, pa;
        f = m_first(lk_ea, cnt);
        if (f < 0) begin
            // R6: every output zero on a miss
            chk("R6", "miss hit/multi/idx", {lk_hit, lk_multi, 26'(lk_idx)}, 64'd0);
            chk("R6", "miss pa/perm/zone/attr", {lk_pa, lk_ex, lk_wr, lk_zone, lk_attr}, 64'd0);
        end else begin
            sh = 10 + 2 * int'(m_tag[f][9:7]);
            lo = (32'h1 << sh) - 32'h1;
            pa = (m_dat[f] & ~lo) | (lk_ea & lo);
            // R7: lowest index wins, multi flag above one match
            chk("R7", "hit/multi/idx", {lk_hit, lk_multi, 26'(lk_idx)}, {1'b1, cnt > 1, 26'(f)});
            chk("R5", "translated address", 64'(lk_pa), 64'(pa));
            chk("R6", "perm/zone/attr", {lk_ex, lk_wr, lk_zone, lk_attr}, 64'(m_dat[f][9:0]));
        end
    endtask

    // One clock: drive after a falling edge, check lookup before the rising edge,
    // update the model at the rising edge, check registered results after.
    task automatic step(input logic [1:0] op, input int idx, input logic wd,
                        input logic [31:0] wdata, input logic [31:0] sea, input logic [31:0] lea);
        int cnt;
        sw_op = op; sw_idx = IW'(idx); sw_word = wd; sw_wdata = wdata; sw_ea = sea; lk_ea = lea;
        #1;
        check_lookup();   // R9: a same-cycle write is not yet visible
        if (op == 2'd1) e_rdata = wd ? m_dat[idx] : m_tag[idx];
        if (op == 2'd3) begin
            e_fidx  = m_first(sea, cnt);
            e_found = (e_fidx >= 0);
            if (!e_found) e_fidx = 0;
        end
        if (op == 2'd2) begin
            if (wd) m_dat[idx] = wdata;
            else    m_tag[idx] = wdata & 32'hFFFF_FFC0;
        end
        @(negedge clk);
        chk("R3", "read word", 64'(sw_rdata), 64'(e_rdata));
        chk("R8", "search result", {sw_found, 26'(sw_fidx)}, {e_found, 26'(e_fidx)});
    endtask

    function automatic logic [31:0] mk_tag(input logic [31:0] epn_addr, input int psz, input bit v);
        return (epn_addr & 32'hFFFF_FC00) | (32'(psz) << 7) | (v ? 32'h40 : 32'h0);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_dat[i] = '0; end
        e_rdata = '0; e_found = 1'b0; e_fidx = 0;
        rst = 1'b1; sw_op = 2'd0; sw_idx = '0; sw_word = 1'b0; sw_wdata = '0; sw_ea = '0; lk_ea = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "reset rdata/found", {sw_rdata, sw_found, 26'(sw_fidx)}, 64'd0);
        step(2'd0, 0, 1'b0, 0, 32'h0, 32'h0);
        step(2'd1, N - 1, 1'b0, 0, 32'h0, 32'h1234_5678);   // R1 read after reset
        step(2'd3, 0, 1'b0, 0, 32'h0, 32'h0);               // R1 search misses

        // R2: 1K page at entry 5, write both words; lookup same cycle as write (R9)
        step(2'd2, 5, 1'b0, mk_tag(32'h1000_0400, 0, 1'b1) | 32'h3F, 32'h0, 32'h1000_0400);
        step(2'd2, 5, 1'b1, 32'hABCD_E7A5, 32'h0, 32'h1000_0400);
        step(2'd0, 0, 1'b0, 0, 32'h0, 32'h1000_07FF);       // R4 inside 1K page
        step(2'd0, 0, 1'b0, 0, 32'h0, 32'h1000_0800);       // R4 just outside
        step(2'd1, 5, 1'b0, 0, 32'h0, 32'h1000_03FF);       // R3 tag low bits read zero
        step(2'd1, 5, 1'b1, 0, 32'h0, 32'h0);               // R3 data word

        // 16M page at entry 63, 64K page at entry 2
        step(2'd2, 63, 1'b0, mk_tag(32'h4200_0000, 7, 1'b1), 32'h0, 32'h0);
        step(2'd2, 63, 1'b1, 32'h9900_035F, 32'h0, 32'h0);
        step(2'd0, 0, 1'b0, 0, 32'h0, 32'h42FF_FFFF);       // R5 offset of 24 bits
        step(2'd0, 0, 1'b0, 0, 32'h0, 32'h4300_0000);
        step(2'd2, 2, 1'b0, mk_tag(32'h42AB_0000, 3, 1'b1), 32'h0, 32'h42AB_0000);
        step(2'd2, 2, 1'b1, 32'h0007_01F0, 32'h0, 32'h0);
        // R7: entries 2 and 63 overlap, index 2 wins with multi
        step(2'd3, 0, 1'b0, 0, 32'h42AB_1234, 32'h42AB_FFFF);
        step(2'd3, 0, 1'b0, 0, 32'h42AC_0000, 32'h42AC_0000); // only entry 63
        // R10: invalidate entry 2 but keep its page number
        step(2'd2, 2, 1'b0, mk_tag(32'h42AB_0000, 3, 1'b0), 32'h0, 32'h42AB_0000);
        step(2'd3, 0, 1'b0, 0, 32'h42AB_0000, 32'h42AB_0000);
        step(2'd1, 2, 1'b0, 0, 32'h0, 32'h0);
        // R2: rewriting the tag leaves the data word alone
        step(2'd1, 2, 1'b1, 0, 32'h0, 32'h0);

        // Random phase over clustered addresses
        for (int n = 0; n < 600; n++) begin
            logic [31:0] bases [4];
            logic [31:0] a, b, w;
            int op, ix;
            bases[0] = 32'h1000_0000; bases[1] = 32'h1004_0000;
            bases[2] = 32'h4200_0000; bases[3] = 32'hFFFF_F000;
            a  = bases[$urandom_range(3)] + ($urandom & 32'h0003_FFFF);
            b  = bases[$urandom_range(3)] + ($urandom & 32'h0003_FFFF);
            op = $urandom_range(3);
            ix = ($urandom_range(1) == 0) ? $urandom_range(7) : $urandom_range(N - 1);
            w  = ($urandom_range(1) == 0) ? mk_tag(b, $urandom_range(7), $urandom_range(3) != 0) : $urandom;
            step(2'(op), ix, (op == 2) ? (w[5:0] != 6'd0 && $urandom_range(1) == 1) : 1'($urandom_range(1)),
                 w, b, a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule